// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an on-chip host and an external asynchronous static RAM of 524,288 bytes. The host gives a request with a 19-bit word address, a write flag and a write byte. The block then runs the memory's active-low chip enable, output enable and write enable pins, the address bus and a split tri-state data bus (value, drive enable, sampled input). When the access is over, it raises a one-cycle acknowledge and, for a read, returns the byte.

Two parameters, each at least 1, set how many clock cycles a read and a write pulse last. They are worked out from the clock period and the memory's speed grade (10 to 20 ns access and cycle time, 4 to 7 ns output-enable time).

Writes are controlled by write enable. The memory takes the data on the rising write-enable edge. Every access ends in a closing cycle with both output enable and write enable high. That cycle is the write hold cycle, or the bus turnaround after a read. The block drives the data pins only once output enable has been high for a full cycle. When no request is pending, chip enable goes high and the memory sits in standby.

Host convention: a request is taken at a clock edge where the block is idle or is raising its acknowledge. The host keeps `host_req` and the request fields steady until it sees the acknowledge for that request. In the acknowledge cycle the host either puts up the next request or lowers `host_req`.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the block goes idle after that edge, even in the middle of an access. Idle means `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe` is 0 and `host_ack` is 0.
- R2: If no request is pending when an acknowledge cycle ends, or while the block is idle, `sram_ce_n` is 1, both other enables are 1 and the data bus is released.
- R3: A read keeps `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for exactly RD_WAIT cycles, starting the cycle after acceptance. The bus value at the end of the last such cycle appears on `host_rdata`. `host_ack` is 1 in cycle RD_WAIT+1 after acceptance.
- R4: A write has three phases:
  - one setup cycle with `sram_ce_n`=0, `sram_we_n`=1 and data driven;
  - WR_WAIT cycles with `sram_we_n`=0;
  - a hold cycle with `sram_we_n`=1, still driving data.

  The memory stores the byte on the rising `sram_we_n` edge. `host_ack` is 1 in cycle WR_WAIT+2 after acceptance.
- R5: `sram_addr` equals the accepted address through the whole access. It never changes while `sram_we_n` is 0, in the cycle where `sram_we_n` rises, or between two read cycles in a row.
- R6: `sram_dq_oe` is 1 only when `sram_oe_n` is 1 in the current and the previous cycle. Data and drive enable stay unchanged across the rising `sram_we_n` edge. The memory and the block never drive the bus in the same cycle.
- R7: `host_ack` is a single-cycle pulse: it is never 1 in two cycles in a row.
- R8: A request taken in an acknowledge cycle starts its access in the next cycle, with `sram_ce_n` held at 0 and no standby cycle in between.
- R9: `host_rdata` changes only when a read completes; writes leave it unchanged.
- R10: `sram_oe_n` and `sram_we_n` are never 0 together, and either being 0 implies `sram_ce_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request pending |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Byte returned by the last read |
| host_ack | output | 1 | One-cycle completion pulse |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_addr | output | 19 | Memory address bus |
| sram_dq_out | output | 8 | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_in | input | 8 | Sampled data bus |

## Verification
The assertions check the following on every cycle:
- the pin protocol (R10);
- address stability across read cycles and around the write-enable pulse (R5);
- drive only after a full cycle with output enable high, and data held over the write-enable rise (R6);
- the single-cycle acknowledge (R7).

Only the bench's scenarios can show:
- the exact pulse widths and acknowledge latencies (R3, R4);
- that written bytes come back from the memory model, and that `host_rdata` is left alone by writes (R9);
- standby after the last access (R2);
- back-to-back chaining with chip enable held low (R8);
- reset during a read (R1).

The memory model in the bench also counts any cycle in which both sides drive the bus.

// File: rtl/sram_ctrl_pkg.sv
// Shared types for the static RAM access sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sram_ctrl_pkg;

    // Sequencer phases: standby, read wait, write setup, write pulse, closing cycle
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_WS   = 3'd2,
        ST_WP   = 3'd3,
        ST_FIN  = 3'd4
    } seq_st_t;

endpackage

// File: rtl/sram_wait_ctr.sv
// Down-counter that times the read wait and the write-enable pulse.
// Loaded with (cycles - 1) on entry to a timed phase; zero marks the last cycle.
// Assumes: load and the zero-hold never conflict (load wins).
module sram_wait_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] init,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    // Count down to zero after each load, then hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= init;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Last cycle of the timed phase
    always_comb zero = (cnt == '0);

endmodule

// File: rtl/sram_seq.sv
// Phase sequencer: takes host requests, steps through read or write phases,
// registers the three memory enables and the acknowledge from the next phase.
// Assumes: RD_WAIT >= 1 and WR_WAIT >= 1; the host holds req steady until ack.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_WAIT = 2,
    parameter int WR_WAIT = 2,
    parameter int CNT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_init,
    output logic             accept,
    output logic             capture,
    output logic             drive_nxt,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             ack
);

    localparam logic [CNT_W-1:0] RD_INIT = CNT_W'(RD_WAIT - 1);
    localparam logic [CNT_W-1:0] WR_INIT = CNT_W'(WR_WAIT - 1);

    seq_st_t st;
    seq_st_t nxt;

    // Requests are taken while idle or in the closing (ack) cycle
    always_comb accept = req && ((st == ST_IDLE) || (st == ST_FIN));

    // Next-phase selection
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE, ST_FIN: nxt = accept ? (req_we ? ST_WS : ST_RD) : ST_IDLE;
            ST_RD:           nxt = cnt_zero ? ST_FIN : ST_RD;
            ST_WS:           nxt = ST_WP;
            ST_WP:           nxt = cnt_zero ? ST_FIN : ST_WP;
            default:         nxt = ST_IDLE;
        endcase
    end

    // Counter reload on entry to a timed phase
    always_comb begin
        cnt_load = ((nxt == ST_RD) && (st != ST_RD)) || ((nxt == ST_WP) && (st != ST_WP));
        cnt_init = (nxt == ST_RD) ? RD_INIT : WR_INIT;
    end

    // Read byte is sampled at the end of the last read cycle
    always_comb capture = (st == ST_RD) && cnt_zero;

    // Data is driven from write setup through the write hold cycle
    always_comb drive_nxt = (nxt == ST_WS) || (nxt == ST_WP) ||
                            ((nxt == ST_FIN) && (st == ST_WP));

    // Phase register and registered pin controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            ce_n <= 1'b1;
            oe_n <= 1'b1;
            we_n <= 1'b1;
            ack  <= 1'b0;
        end else begin
            st   <= nxt;
            ce_n <= (nxt == ST_IDLE);
            oe_n <= (nxt != ST_RD);
            we_n <= (nxt != ST_WP);
            ack  <= (nxt == ST_FIN);
        end
    end

endmodule

// File: rtl/sram_io.sv
// Address and data path: latches the address and write byte at acceptance,
// drives the data bus on request and captures the read byte.
// Assumes: accept, capture and drive_nxt come from the phase sequencer.
module sram_io #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              wr_req,
    input  logic              capture,
    input  logic              drive_nxt,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rdata
);

    // Address register, loaded only when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n)
            mem_addr <= '0;
        else if (accept)
            mem_addr <= host_addr;
    end

    // Write byte register and bus drive enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else begin
            if (accept && wr_req)
                dq_out <= host_wdata;
            dq_oe <= drive_nxt;
        end
    end

    // Read byte capture at the end of the read wait
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (capture)
            rdata <= dq_in;
    end

endmodule

// File: rtl/sram_ctrl.sv
// Top: host request/acknowledge port to an asynchronous static RAM.
// Write-enable-controlled writes, timed read waits, standby when idle.
// Assumes: RD_WAIT and WR_WAIT >= 1, chosen from clock period and speed grade.
module sram_ctrl #(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int RD_WAIT = 2,
    parameter int WR_WAIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ack,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int MAX_WAIT = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_init;
    logic             cnt_zero;
    logic             accept;
    logic             capture;
    logic             drive_nxt;

    sram_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cnt_load),
        .init (cnt_init),
        .zero (cnt_zero)
    );

    sram_seq #(.RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (host_req),
        .req_we   (host_we),
        .cnt_zero (cnt_zero),
        .cnt_load (cnt_load),
        .cnt_init (cnt_init),
        .accept   (accept),
        .capture  (capture),
        .drive_nxt(drive_nxt),
        .ce_n     (sram_ce_n),
        .oe_n     (sram_oe_n),
        .we_n     (sram_we_n),
        .ack      (host_ack)
    );

    sram_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .wr_req    (host_we),
        .capture   (capture),
        .drive_nxt (drive_nxt),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .dq_in     (sram_dq_in),
        .mem_addr  (sram_addr),
        .dq_out    (sram_dq_out),
        .dq_oe     (sram_dq_oe),
        .rdata     (host_rdata)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
// Protocol checker for the static RAM sequencer pins, bound into sram_ctrl.
// Assumes: synchronous active-low reset; all checks are off while it is low.
module sram_ctrl_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));                                               // R10
    AST_EN_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> !ce_n);                                      // R10
    AST_ADDR_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> $stable(addr));                                         // R5
    AST_ADDR_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> $stable(addr));                                   // R5
    AST_ADDR_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !$past(oe_n)) |-> $stable(addr));                       // R5
    AST_DRIVE_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_n && $past(oe_n)));                                 // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (dq_oe && $stable(dq_out)));                      // R6
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);                                                    // R7

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ack   (host_ack),
    .ce_n  (sram_ce_n),
    .oe_n  (sram_oe_n),
    .we_n  (sram_we_n),
    .addr  (sram_addr),
    .dq_out(sram_dq_out),
    .dq_oe (sram_dq_oe)
);

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/1ps
// Bench for sram_ctrl: behavioural memory with a contention counter,
// a vector table walked by one loop, then directed reset and chaining tests.
module sim_sram_ctrl;

    localparam int AW  = 19;
    localparam int DW  = 8;
    localparam int RDW = 3;
    localparam int WRW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_ack;
    logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_dq_out, sram_dq_in;

    int checks = 0;
    int failures = 0;
    int contention = 0;
    int bad_pins = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_WAIT(RDW), .WR_WAIT(WRW)) u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ack(host_ack), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // Memory model: 256 slots tagged with the full address
    logic [DW-1:0] mdat [256];
    logic [AW-1:0] mtag [256];
    logic          mvld [256];
    logic          mem_drv;
    logic [DW-1:0] mem_val;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mdat[i] = '0; mtag[i] = '0; mvld[i] = 1'b0;
        end
    end

    always @(posedge sram_we_n) begin
        if (sram_ce_n === 1'b0) begin
            mdat[sram_addr[7:0]] <= sram_dq_out;
            mtag[sram_addr[7:0]] <= sram_addr;
            mvld[sram_addr[7:0]] <= 1'b1;
        end
    end

    assign mem_drv = (sram_ce_n == 1'b0) && (sram_oe_n == 1'b0) && (sram_we_n == 1'b1);
    assign mem_val = (mvld[sram_addr[7:0]] && mtag[sram_addr[7:0]] == sram_addr)
                     ? mdat[sram_addr[7:0]] : 8'h00;
    assign sram_dq_in = sram_dq_oe ? sram_dq_out : (mem_drv ? mem_val : 8'h00);

    // Bus and pin monitors, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (sram_dq_oe && mem_drv) contention++;
            if ((!sram_oe_n && !sram_we_n) || ((!sram_oe_n || !sram_we_n) && sram_ce_n))
                bad_pins++;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; failures++;
            $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    logic [DW-1:0] mem_peek;
    task automatic peek(input logic [AW-1:0] a);
        mem_peek = (mvld[a[7:0]] && mtag[a[7:0]] == a) ? mdat[a[7:0]] : 8'h00;
    endtask

    // One access from idle; returns cycles to ack, pulse widths and address errors
    int lat, oe_lo, we_lo, addr_bad;
    logic setup_ok;
    task automatic access(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int cyc = 0;
        lat = 0; oe_lo = 0; we_lo = 0; addr_bad = 0; setup_ok = 1'b0;
        host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (!sram_oe_n) oe_lo++;
            if (!sram_we_n) we_lo++;
            if (sram_addr !== a) addr_bad++;
            if (cyc == 1) setup_ok = !sram_ce_n && sram_we_n && sram_oe_n && sram_dq_oe;
            if (host_ack || cyc > 50) break;
        end
        lat = cyc;
        host_req = 1'b0;
    endtask

    // Vector table: {write, address, write byte, expected read byte}
    localparam int NV = 10;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 19'h00000, 8'hA5, 8'h00},
        {1'b1, 19'h7FFFF, 8'h5A, 8'h00},
        {1'b1, 19'h12345, 8'h3C, 8'h00},
        {1'b1, 19'h6AAAA, 8'hFF, 8'h00},
        {1'b0, 19'h00000, 8'h00, 8'hA5},
        {1'b0, 19'h7FFFF, 8'h00, 8'h5A},
        {1'b0, 19'h12345, 8'h00, 8'h3C},
        {1'b1, 19'h12345, 8'h00, 8'h00},
        {1'b0, 19'h12345, 8'h00, 8'h00},
        {1'b0, 19'h6AAAA, 8'h00, 8'hFF}
    };

    initial begin
        logic [DW-1:0] last_rd;
        last_rd = 8'h00;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 reset enables", {29'd0, sram_ce_n, sram_oe_n, sram_we_n}, 32'h7);
        chk("R1 reset bus/ack", {30'd0, sram_dq_oe, host_ack}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 idle standby", {28'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 32'hE);

        for (int v = 0; v < NV; v++) begin
            logic          vw;
            logic [AW-1:0] va;
            logic [DW-1:0] vd, ve;
            {vw, va, vd, ve} = VEC[v];
            access(vw, va, vd);
            chk("R5 address held", addr_bad, 0);
            if (vw) begin
                chk("R4 write latency", lat, WRW + 2);
                chk("R4 we pulse width", we_lo, WRW);
                chk("R4 setup cycle", {31'd0, setup_ok}, 1);
                chk("R10 no oe in write", oe_lo, 0);
                chk("R9 rdata kept on write", {24'd0, host_rdata}, {24'd0, last_rd});
                peek(va);
                chk("R4 memory stored byte", {24'd0, mem_peek}, {24'd0, vd});
            end else begin
                chk("R3 read latency", lat, RDW + 1);
                chk("R3 oe pulse width", oe_lo, RDW);
                chk("R3 read data", {24'd0, host_rdata}, {24'd0, ve});
                last_rd = ve;
            end
            @(negedge clk);
            chk("R7 ack single cycle", {31'd0, host_ack}, 0);
            chk("R2 standby after access", {30'd0, sram_ce_n, sram_dq_oe}, 32'h2);
        end

        // R8: read -> write -> read chained with no standby cycle
        access(1'b0, 19'h00000, 8'h00);
        chk("R8 ce low in ack cycle", {31'd0, sram_ce_n}, 0);
        host_req = 1'b1; host_we = 1'b1; host_addr = 19'h55555; host_wdata = 8'hC3;
        @(negedge clk);
        chk("R8 write setup follows ack", {29'd0, sram_ce_n, sram_we_n, sram_dq_oe}, 32'h3);
        while (!host_ack) @(negedge clk);
        host_we = 1'b0; host_addr = 19'h55555;
        @(negedge clk);
        chk("R8 read follows write ack", {30'd0, sram_ce_n, sram_oe_n}, 32'h0);
        while (!host_ack) @(negedge clk);
        host_req = 1'b0;
        chk("R8 chained read data", {24'd0, host_rdata}, 32'hC3);
        @(negedge clk);
        chk("R2 standby after chain", {31'd0, sram_ce_n}, 1);

        // R1: reset in the middle of a read
        host_req = 1'b1; host_we = 1'b0; host_addr = 19'h7FFFF;
        @(negedge clk);
        host_req = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-read", {28'd0, sram_ce_n, sram_oe_n, sram_we_n, host_ack}, 32'hE);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {30'd0, sram_ce_n, sram_dq_oe}, 32'h2);

        chk("R6 bus contention cycles", contention, 0);
        chk("R10 enable rule breaks", bad_pins, 0);
        summary();
        $finish;
    end

endmodule